// File: doc/BRIEF.md
# Segmented Logical Address Translator

This block turns a logical address, made of a segment selector and a 32-bit offset, into a 32-bit linear address. A protection-enable input chooses between two modes. In real mode the selector value itself is the paragraph number, shifted and added to a 16-bit offset. In protected mode the selector points at an 8-byte descriptor in one of two descriptor tables. The block fetches that descriptor once, when the selector is loaded, and keeps its decoded base and limit in a hidden shadow entry owned by that segment register.

A load request names a segment register and a selector. In protected mode the block computes the descriptor address and reads it over a 32-bit memory read port: first the low word, then the high word. It then updates the shadow entry, or reports a not-present fault and leaves the entry as it was. Translation requests name a segment register and an offset. They never touch memory. Each one returns either a linear address or a limit fault, one cycle later.

Top module: `seg_xlate`

## Requirements
- R1: After reset, ld_ready_o is 1, mem_req_o, xl_valid_o and xl_limit_fault_o are 0, and every shadow entry has base 0, effective limit 0 and selector 0. A protected-mode offset of 0 therefore translates to 0, and an offset of 1 raises a limit fault.
- R2: With pe_i=0, a load completes without any memory read and sets that entry's selector. A translation then returns ((selector << 4) + offset[15:0]) modulo 2^20, with bits 31..20 zero, and never a limit fault.
- R3: In protected mode the selector index is bits 15..3 and the table indicator is bit 2 (0: gdt_base_i, 1: ldt_base_i). The first read goes to table base + index*8 and the second to that address + 4.
- R4: The low descriptor word holds limit[15:0] in bits 15..0 and base[15:0] in bits 31..16. The high word holds base[23:16] in bits 7..0, present in bit 15, limit[19:16] in bits 19..16, granularity in bit 23 and base[31:24] in bits 31..24. Bits 11..8, 12, 14..13, 20..22 carry type, S, DPL and other flags and do not affect translation.
- R5: A descriptor whose present bit is 0 raises ld_np_fault_o in the completion cycle, and that shadow entry keeps its previous contents.
- R6: The effective limit is the 20-bit limit when granularity is 0, and (limit << 12) | 0xFFF when granularity is 1.
- R7: In protected mode, an offset above the effective limit asserts xl_limit_fault_o and not xl_valid_o. An offset equal to the limit is valid.
- R8: A valid protected-mode translation returns (shadow base + offset) modulo 2^32.
- R9: mem_req_o stays high, with mem_addr_o unchanged, until mem_ack_i. mem_rdata_i is taken in the cycle of the acknowledge.
- R10: Translations cause no memory reads. Each segment register's shadow entry is independent of the others.
- R11: ld_ready_o is low from the accepting edge until the load finishes. ld_done_o is a one-cycle pulse, and the shadow entry is usable from the cycle after it.
- R12: A translation request sampled at a clock edge yields exactly one of xl_valid_o or xl_limit_fault_o in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pe_i | input | 1 | 1 selects protected mode, 0 real mode |
| gdt_base_i | input | 32 | Global descriptor table base |
| ldt_base_i | input | 32 | Local descriptor table base |
| ld_valid_i | input | 1 | Selector load request |
| ld_seg_i | input | SEG_IDX_W | Segment register being loaded |
| ld_sel_i | input | 16 | Selector value |
| ld_ready_o | output | 1 | Load port idle, request accepted |
| ld_done_o | output | 1 | Load finished this cycle |
| ld_np_fault_o | output | 1 | Loaded descriptor not present |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 32 | Read data |
| xl_valid_i | input | 1 | Translation request |
| xl_seg_i | input | SEG_IDX_W | Segment register used |
| xl_off_i | input | 32 | Offset |
| xl_valid_o | output | 1 | Linear address valid |
| xl_lin_o | output | 32 | Linear address |
| xl_limit_fault_o | output | 1 | Offset beyond segment limit |

## Verification
The hardest situation to reach is the boundary of a granular limit. The offsets where a fault begins lie at exactly (limit << 12) | 0xFFF and one above it, and random offsets almost never land there. The stimulus loads random descriptors with a random granularity bit and then aims offsets at the effective limit and the limit plus one, as well as random ones. Not-present descriptors are mixed in, followed by translations through the same register, so a corrupted shadow entry shows up at the output. The memory model acknowledges after random delays, which exercises the request-hold rule.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_LO   = 2'd1,
    FS_HI   = 2'd2,
    FS_DONE = 2'd3
  } fetch_st_e;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] lim;     // effective byte limit
    logic        present;
  } seg_desc_t;

  function automatic seg_desc_t decode_desc(input logic [31:0] lo, input logic [31:0] hi);
    seg_desc_t   d;
    logic [19:0] raw;
    raw       = {hi[19:16], lo[15:0]};
    d.base    = {hi[31:24], hi[7:0], lo[31:16]};
    d.present = hi[15];
    d.lim     = hi[23] ? {raw, 12'hFFF} : {12'h000, raw};
    return d;
  endfunction

endpackage

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_xlate_pkg::*;
#(
  parameter int SEG_IDX_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pe_i,
  input  logic [31:0]          gdt_base_i,
  input  logic [31:0]          ldt_base_i,
  input  logic                 ld_valid_i,
  input  logic [SEG_IDX_W-1:0] ld_seg_i,
  input  logic [15:0]          ld_sel_i,
  output logic                 ld_ready_o,
  output logic                 ld_done_o,
  output logic                 ld_np_fault_o,
  output logic                 mem_req_o,
  output logic [31:0]          mem_addr_o,
  input  logic                 mem_ack_i,
  input  logic [31:0]          mem_rdata_i,
  output logic                 wr_en_o,
  output logic [SEG_IDX_W-1:0] wr_seg_o,
  output logic [15:0]          wr_sel_o,
  output seg_desc_t            wr_desc_o
);

  fetch_st_e            state_q;
  logic [SEG_IDX_W-1:0] seg_q;
  logic [15:0]          sel_q;
  logic                 real_q;
  logic [31:0]          addr_q, lo_q, hi_q;
  seg_desc_t            dec;
  seg_desc_t            real_desc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      seg_q   <= '0;
      sel_q   <= '0;
      real_q  <= 1'b0;
      addr_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      unique case (state_q)
        FS_IDLE: if (ld_valid_i) begin
          seg_q   <= ld_seg_i;
          sel_q   <= ld_sel_i;
          real_q  <= !pe_i;
          addr_q  <= (ld_sel_i[2] ? ldt_base_i : gdt_base_i) + {16'h0, ld_sel_i[15:3], 3'b000};
          state_q <= pe_i ? FS_LO : FS_DONE;
        end
        FS_LO: if (mem_ack_i) begin
          lo_q    <= mem_rdata_i;
          addr_q  <= addr_q + 32'd4;
          state_q <= FS_HI;
        end
        FS_HI: if (mem_ack_i) begin
          hi_q    <= mem_rdata_i;
          state_q <= FS_DONE;
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  always_comb begin
    dec               = decode_desc(lo_q, hi_q);
    real_desc.base    = {12'h000, sel_q, 4'h0};
    real_desc.lim     = 32'h0000_FFFF;
    real_desc.present = 1'b1;
  end

  assign ld_ready_o    = (state_q == FS_IDLE);
  assign ld_done_o     = (state_q == FS_DONE);
  assign mem_req_o     = (state_q == FS_LO) || (state_q == FS_HI);
  assign mem_addr_o    = addr_q;
  assign ld_np_fault_o = ld_done_o && !real_q && !dec.present;
  assign wr_en_o       = ld_done_o && (real_q || dec.present);
  assign wr_seg_o      = seg_q;
  assign wr_sel_o      = sel_q;
  assign wr_desc_o     = real_q ? real_desc : dec;

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  p_ready_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_ready_o && (mem_req_o || ld_done_o)));

  p_hi_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == FS_LO) && mem_ack_i |=> mem_addr_o == $past(mem_addr_o) + 32'd4);

endmodule

// File: rtl/seg_shadow_file.sv
module seg_shadow_file
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG   = 6,
  parameter int SEG_IDX_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [SEG_IDX_W-1:0] wr_seg_i,
  input  logic [15:0]          wr_sel_i,
  input  seg_desc_t            wr_desc_i,
  input  logic [SEG_IDX_W-1:0] rd_seg_i,
  output logic [15:0]          rd_sel_o,
  output seg_desc_t            rd_desc_o
);

  logic [15:0] sel_q  [NUM_SEG];
  seg_desc_t   desc_q [NUM_SEG];

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q[s]  <= '0;
        desc_q[s] <= '0;
      end else if (wr_en_i && (wr_seg_i == SEG_IDX_W'(s))) begin
        sel_q[s]  <= wr_sel_i;
        desc_q[s] <= wr_desc_i;
      end
    end
  end

  always_comb begin
    rd_sel_o  = '0;
    rd_desc_o = '0;
    for (int s = 0; s < NUM_SEG; s++) begin
      if (rd_seg_i == SEG_IDX_W'(s)) begin
        rd_sel_o  = sel_q[s];
        rd_desc_o = desc_q[s];
      end
    end
  end

  p_wr_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> int'(wr_seg_i) < NUM_SEG);

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_xlate_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pe_i,
  input  logic        xl_valid_i,
  input  logic [31:0] xl_off_i,
  input  logic [15:0] sel_i,
  input  seg_desc_t   desc_i,
  output logic        xl_valid_o,
  output logic [31:0] xl_lin_o,
  output logic        xl_limit_fault_o
);

  logic [19:0] real_sum;
  logic        over;
  logic        real_q;

  assign real_sum = {sel_i, 4'h0} + {4'h0, xl_off_i[15:0]};
  assign over     = xl_off_i > desc_i.lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xl_valid_o       <= 1'b0;
      xl_limit_fault_o <= 1'b0;
      xl_lin_o         <= '0;
      real_q           <= 1'b0;
    end else begin
      xl_valid_o       <= xl_valid_i && (!pe_i || !over);
      xl_limit_fault_o <= xl_valid_i && pe_i && over;
      real_q           <= !pe_i;
      if (xl_valid_i)
        xl_lin_o <= pe_i ? desc_i.base + xl_off_i : {12'h000, real_sum};
    end
  end

  p_out_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xl_valid_o && xl_limit_fault_o));

  p_one_result_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_valid_i |=> (xl_valid_o || xl_limit_fault_o));

  p_real_20bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_valid_o && real_q |-> xl_lin_o[31:20] == 12'h000);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG   = 6,
  parameter int SEG_IDX_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pe_i,
  input  logic [31:0]          gdt_base_i,
  input  logic [31:0]          ldt_base_i,
  input  logic                 ld_valid_i,
  input  logic [SEG_IDX_W-1:0] ld_seg_i,
  input  logic [15:0]          ld_sel_i,
  output logic                 ld_ready_o,
  output logic                 ld_done_o,
  output logic                 ld_np_fault_o,
  output logic                 mem_req_o,
  output logic [31:0]          mem_addr_o,
  input  logic                 mem_ack_i,
  input  logic [31:0]          mem_rdata_i,
  input  logic                 xl_valid_i,
  input  logic [SEG_IDX_W-1:0] xl_seg_i,
  input  logic [31:0]          xl_off_i,
  output logic                 xl_valid_o,
  output logic [31:0]          xl_lin_o,
  output logic                 xl_limit_fault_o
);

  logic                 wr_en;
  logic [SEG_IDX_W-1:0] wr_seg;
  logic [15:0]          wr_sel;
  seg_desc_t            wr_desc;
  logic [15:0]          rd_sel;
  seg_desc_t            rd_desc;

  seg_desc_fetch #(.SEG_IDX_W(SEG_IDX_W)) i_fetch (
    .clk_i, .rst_ni, .pe_i, .gdt_base_i, .ldt_base_i,
    .ld_valid_i, .ld_seg_i, .ld_sel_i, .ld_ready_o, .ld_done_o, .ld_np_fault_o,
    .mem_req_o, .mem_addr_o, .mem_ack_i, .mem_rdata_i,
    .wr_en_o(wr_en), .wr_seg_o(wr_seg), .wr_sel_o(wr_sel), .wr_desc_o(wr_desc)
  );

  seg_shadow_file #(.NUM_SEG(NUM_SEG), .SEG_IDX_W(SEG_IDX_W)) i_shadow (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_seg_i(wr_seg), .wr_sel_i(wr_sel), .wr_desc_i(wr_desc),
    .rd_seg_i(xl_seg_i), .rd_sel_o(rd_sel), .rd_desc_o(rd_desc)
  );

  seg_addr_gen i_agen (
    .clk_i, .rst_ni, .pe_i, .xl_valid_i, .xl_off_i,
    .sel_i(rd_sel), .desc_i(rd_desc),
    .xl_valid_o, .xl_lin_o, .xl_limit_fault_o
  );

  p_fault_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_np_fault_o |-> !wr_en && ld_done_o);

endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  localparam int NS = 6;
  localparam int SW = 3;

  logic          clk = 0, rst_n = 0, pe = 1;
  logic [31:0]   gdt_base = 32'h0001_0000, ldt_base = 32'h0080_0000;
  logic          ld_valid = 0;
  logic [SW-1:0] ld_seg = 0;
  logic [15:0]   ld_sel = 0;
  logic          ld_ready, ld_done, ld_np_fault, mem_req, mem_ack = 0;
  logic [31:0]   mem_addr, mem_rdata = 0;
  logic          xl_valid = 0;
  logic [SW-1:0] xl_seg = 0;
  logic [31:0]   xl_off = 0;
  logic          xl_vo, xl_fo;
  logic [31:0]   xl_lin;

  int checks = 0, fails = 0, reads = 0, seed_init;
  logic [31:0] exp_addr, exp_lo, exp_hi;
  logic [31:0] m_base [NS];
  logic [31:0] m_lim  [NS];
  logic [15:0] m_sel  [NS];

  always #5ns clk = ~clk;

  seg_xlate #(.NUM_SEG(NS)) i_seg_xlate (
    .clk_i(clk), .rst_ni(rst_n), .pe_i(pe), .gdt_base_i(gdt_base), .ldt_base_i(ldt_base),
    .ld_valid_i(ld_valid), .ld_seg_i(ld_seg), .ld_sel_i(ld_sel), .ld_ready_o(ld_ready),
    .ld_done_o(ld_done), .ld_np_fault_o(ld_np_fault), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .xl_valid_i(xl_valid), .xl_seg_i(xl_seg), .xl_off_i(xl_off),
    .xl_valid_o(xl_vo), .xl_lin_o(xl_lin), .xl_limit_fault_o(xl_fo)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_lo(input logic [31:0] b, input logic [19:0] l);
    return {b[15:0], l[15:0]};
  endfunction

  function automatic logic [31:0] mk_hi(input logic [31:0] b, input logic [19:0] l,
                                        input logic g, input logic p, input logic [7:0] junk);
    return {b[31:24], g, junk[0], 1'b0, junk[1], l[19:16], p, junk[3:2], 1'b1, junk[7:4], b[23:16]};
  endfunction

  function automatic logic [31:0] eff_lim(input logic [19:0] l, input logic g);
    return g ? {l, 12'hFFF} : {12'h0, l};
  endfunction

  // memory model: random wait, answers only the two expected addresses (R3, R9)
  initial begin
    int wait_cnt;
    wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 0;
        wait_cnt = $urandom_range(0, 3);
      end else if (mem_req) begin
        if (wait_cnt == 0) begin
          mem_ack = 1;
          reads++;
          if (mem_addr == exp_addr) mem_rdata = exp_lo;
          else if (mem_addr == exp_addr + 32'd4) mem_rdata = exp_hi;
          else begin
            mem_rdata = 32'hDEAD_BEEF;
            chk("R3 read address", {32'h0, mem_addr}, {32'h0, exp_addr});
          end
        end else wait_cnt--;
      end
    end
  end

  task automatic load(input logic [SW-1:0] s, input logic [15:0] sel,
                      input logic [31:0] b, input logic [19:0] l, input logic g, input logic p);
    int r0, n;
    exp_addr = (sel[2] ? ldt_base : gdt_base) + {16'h0, sel[15:3], 3'b000};
    exp_lo   = mk_lo(b, l);
    exp_hi   = mk_hi(b, l, g, p, 8'($urandom));
    r0 = reads;
    @(negedge clk);
    chk("R11 ready idle", {63'h0, ld_ready}, 64'h1);
    ld_valid = 1; ld_seg = s; ld_sel = sel;
    @(negedge clk);
    ld_valid = 0;
    n = 0;
    while (!ld_done && n < 50) begin
      if (ld_ready) chk("R11 ready low while busy", {63'h0, ld_ready}, 64'h0);
      @(negedge clk); n++;
    end
    chk("R11 done pulse", {63'h0, ld_done}, 64'h1);
    chk("R11 ready low at done", {63'h0, ld_ready}, 64'h0);
    if (!pe) begin
      chk("R2 no memory read", 64'(reads - r0), 64'd0);
      chk("R5 no fault in real mode", {63'h0, ld_np_fault}, 64'h0);
      m_sel[s] = sel; m_base[s] = {12'h0, sel, 4'h0}; m_lim[s] = 32'hFFFF;
    end else begin
      chk("R3 two reads", 64'(reads - r0), 64'd2);
      chk("R5 np fault flag", {63'h0, ld_np_fault}, {63'h0, !p});
      if (p) begin
        m_sel[s] = sel; m_base[s] = b; m_lim[s] = eff_lim(l, g);
      end
    end
    @(negedge clk);
    chk("R11 done one cycle", {63'h0, ld_done}, 64'h0);
  endtask

  task automatic xlate(input logic [SW-1:0] s, input logic [31:0] off, input string req);
    logic [19:0] rs;
    logic ev, ef;
    logic [31:0] el;
    int r0;
    r0 = reads;
    @(negedge clk);
    xl_valid = 1; xl_seg = s; xl_off = off;
    @(negedge clk);
    xl_valid = 0;
    if (!pe) begin
      rs = {m_sel[s], 4'h0} + {4'h0, off[15:0]};
      ev = 1; ef = 0; el = {12'h0, rs};
    end else begin
      ef = off > m_lim[s]; ev = !ef; el = m_base[s] + off;
    end
    chk({req, " R12 valid"}, {63'h0, xl_vo}, {63'h0, ev});
    chk({req, " R7 fault"}, {63'h0, xl_fo}, {63'h0, ef});
    if (ev) chk({req, " R8 linear"}, {32'h0, xl_lin}, {32'h0, el});
    chk("R10 no read on translate", 64'(reads - r0), 64'd0);
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    seed_init = $urandom(32'd4242);
    for (int s = 0; s < NS; s++) begin m_base[s] = 0; m_lim[s] = 0; m_sel[s] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", {63'h0, ld_ready}, 64'h1);
    chk("R1 mem_req", {63'h0, mem_req}, 64'h0);
    chk("R1 xl_valid", {63'h0, xl_vo}, 64'h0);
    chk("R1 fault", {63'h0, xl_fo}, 64'h0);
    rst_n = 1;
    xlate(0, 32'h0, "R1 zero offset");
    xlate(3, 32'h1, "R1 past reset limit");

    // directed: byte granular limit boundary (R4, R6, R7)
    load(1, {13'd5, 1'b0, 2'd0}, 32'h1234_5678, 20'h0_0FFF, 0, 1);
    xlate(1, 32'h0000_0FFF, "R6 byte limit equal");
    xlate(1, 32'h0000_1000, "R6 byte limit plus one");
    // 4K granular via local table (R3, R6)
    load(2, {13'd8191, 1'b1, 2'd3}, 32'hF000_0000, 20'h0_0002, 1, 1);
    xlate(2, 32'h0000_2FFF, "R6 granular limit equal");
    xlate(2, 32'h0000_3000, "R6 granular limit plus one");
    xlate(2, 32'h0000_2000, "R8 base add");
    // not-present leaves entry (R5)
    load(1, {13'd9, 1'b0, 2'd0}, 32'hAAAA_0000, 20'hF_FFFF, 1, 0);
    xlate(1, 32'h0000_0010, "R5 entry kept");
    xlate(1, 32'h0000_1000, "R5 old limit kept");
    // independence (R10)
    xlate(2, 32'h0000_0004, "R10 other entry");
    // wrap of 32-bit sum (R8)
    load(4, {13'd1, 1'b0, 2'd0}, 32'hFFFF_F000, 20'hF_FFFF, 1, 1);
    xlate(4, 32'h0000_2000, "R8 wrap");

    // real mode (R2)
    pe = 0;
    load(5, 16'hFFFF, 0, 0, 0, 0);
    xlate(5, 32'h1234_FFFF, "R2 real wrap 1M");
    xlate(5, 32'h0000_0010, "R2 real");
    load(0, 16'h1234, 0, 0, 0, 0);
    xlate(0, 32'hFFFF_0005, "R2 real high offset ignored");
    pe = 1;
    xlate(0, 32'h0000_FFFF, "R2 real load limit");
    xlate(0, 32'h0001_0000, "R2 real load limit plus one");

    // constrained random
    for (int i = 0; i < 40; i++) begin
      logic [SW-1:0] s;
      logic [19:0] l;
      logic g, p;
      logic [31:0] b, lim;
      s = SW'($urandom_range(0, NS - 1));
      l = 20'($urandom); g = 1'($urandom); p = ($urandom_range(0, 4) != 0);
      b = $urandom;
      gdt_base = {$urandom, 3'b000} ; ldt_base = {$urandom, 3'b000};
      load(s, 16'($urandom), b, l, g, p);
      lim = m_lim[s];
      xlate(s, lim, "R7 rand at limit");
      if (lim != 32'hFFFF_FFFF) xlate(s, lim + 1, "R7 rand over limit");
      xlate(s, $urandom, "R8 rand offset");
      xlate(s, $urandom_range(0, 255), "R8 rand small");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule